// File: doc/BRIEF.md
# Multi-Mode Four-Point Integer Transform

This block performs a one-dimensional four-point integer transform on four signed samples. It supports three transforms from the family used by block-based video codecs: the forward core transform, the inverse core transform and the Hadamard transform. A two-bit mode input selects the transform. All three modes share a single two-stage add/subtract butterfly. Multiplexers pick the operands of the first stage, a shift-or-pass choice sets the weight of two second-stage paths, and a final lane router puts the results in output order. Weights of two are left shifts. Weights of one half are arithmetic right shifts, which round toward negative infinity. The block has no multipliers.

A two-dimensional transform is built by placing two of these units around a transpose store. Any scaling or quantisation is applied outside the block. The combinational result is captured in one output register stage. A sample strobe travels alongside the data with the same single-cycle delay.

Top module: `xf4_unit`

## Requirements
- R1: With mode 2'b00 (forward core), the outputs one cycle later are y0 = x0+x1+x2+x3, y1 = 2x0+x1−x2−2x3, y2 = x0−x1−x2+x3 and y3 = x0−2x1+2x2−x3.
- R2: With mode 2'b01 (inverse core), the outputs one cycle later are y0 = x0+x1+x2+h(x3), y1 = x0+h(x1)−x2−x3, y2 = x0−h(x1)−x2+x3 and y3 = x0−x1+x2−h(x3). Here h(v) is v shifted right arithmetically by one bit (floor of v/2), so h(−3) = −2.
- R3: With mode 2'b10 (Hadamard), the outputs one cycle later are y0 = x0+x1+x2+x3, y1 = x0+x1−x2−x3, y2 = x0−x1−x2+x3 and y3 = x0−x1+x2−x3.
- R4: With mode 2'b11 (reserved), all four outputs are zero one cycle later, whatever the inputs and whatever the previous result.
- R5: valid_out equals the valid_in of the previous clock cycle. The data outputs are registered on every cycle, whatever the state of valid_in.
- R6: While rst_n is low, valid_out and all four outputs are zero.
- R7: Inputs are 16-bit two's complement and outputs are 19-bit two's complement. For every mode, results at the extremes of the input range (−32768 and 32767) are exact and do not wrap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| valid_in | input | 1 | Strobe marking a sample set on x0..x3 |
| mode | input | 2 | 00 forward, 01 inverse, 10 Hadamard, 11 reserved |
| x0 | input | IN_W (16) | Input sample 0, signed |
| x1 | input | IN_W (16) | Input sample 1, signed |
| x2 | input | IN_W (16) | Input sample 2, signed |
| x3 | input | IN_W (16) | Input sample 3, signed |
| valid_out | output | 1 | valid_in delayed by one cycle |
| y0 | output | IN_W+3 (19) | Result lane 0, signed |
| y1 | output | IN_W+3 (19) | Result lane 1, signed |
| y2 | output | IN_W+3 (19) | Result lane 2, signed |
| y3 | output | IN_W+3 (19) | Result lane 3, signed |

## Verification
The only state is the output register, so any fault shows up at the ports exactly one cycle after the inputs that expose it. A wrong first-stage operand choice breaks only the lanes that use the selected pair, usually in one mode only. A wrong weight on the shifted path shows up in lanes 1 and 3 of the forward mode. A wrong route swaps lanes 2 and 3 of the inverse mode. Odd negative samples in inverse mode show whether the half terms round by floor. Extreme-value vectors show whether an internal width is too narrow, which appears as a sign flip in the forward lanes 1 and 3.

// File: rtl/xf4_pkg.sv
package xf4_pkg;

    typedef enum logic [1:0] {
        XF_FWD = 2'b00,
        XF_INV = 2'b01,
        XF_HAD = 2'b10,
        XF_RSV = 2'b11
    } xf_mode_e;

    localparam int LANES = 4;

endpackage

// File: rtl/xf4_stage1.sv
// First butterfly stage: operand selection by mode, then sum/difference pairs.
module xf4_stage1
    import xf4_pkg::*;
#(
    parameter int IN_W = 16,
    parameter int W    = IN_W + 3
) (
    input  xf_mode_e                mode,
    input  logic signed [IN_W-1:0]  x0,
    input  logic signed [IN_W-1:0]  x1,
    input  logic signed [IN_W-1:0]  x2,
    input  logic signed [IN_W-1:0]  x3,
    output logic signed [W-1:0]     m0,
    output logic signed [W-1:0]     m1,
    output logic signed [W-1:0]     m2,
    output logic signed [W-1:0]     m3
);

    logic signed [W-1:0] w0, w1, w2, w3;
    logic signed [W-1:0] half1, half3;
    logic signed [W-1:0] pa, pb, c2, d2, c3, d3;

    assign w0    = W'(x0);
    assign w1    = W'(x1);
    assign w2    = W'(x2);
    assign w3    = W'(x3);
    assign half1 = w1 >>> 1;
    assign half3 = w3 >>> 1;

    always_comb begin
        unique case (mode)
            XF_INV: begin
                pa = w0;    pb = w2;
                c2 = w1;    d2 = half3;
                c3 = half1; d3 = w3;
            end
            default: begin
                pa = w0;    pb = w3;
                c2 = w1;    d2 = w2;
                c3 = w1;    d3 = w2;
            end
        endcase
    end

    assign m0 = pa + pb;
    assign m1 = pa - pb;
    assign m2 = c2 + d2;
    assign m3 = c3 - d3;

endmodule

// File: rtl/xf4_stage2.sv
// Second butterfly stage: fixed adder network, shifted-path weight by mode.
module xf4_stage2
    import xf4_pkg::*;
#(
    parameter int W = 19
) (
    input  xf_mode_e             mode,
    input  logic signed [W-1:0]  m0,
    input  logic signed [W-1:0]  m1,
    input  logic signed [W-1:0]  m2,
    input  logic signed [W-1:0]  m3,
    output logic signed [W-1:0]  n [LANES]
);

    logic                dbl;
    logic signed [W-1:0] sm1, sm3;

    assign dbl = (mode == XF_FWD);
    assign sm1 = dbl ? (m1 <<< 1) : m1;
    assign sm3 = dbl ? (m3 <<< 1) : m3;

    assign n[0] = m0 + m2;
    assign n[1] = m0 - m2;
    assign n[2] = sm1 + m3;
    assign n[3] = m1 - sm3;

endmodule

// File: rtl/xf4_route.sv
// Output lane router: per-mode ordering and reserved-code zeroing.
module xf4_route
    import xf4_pkg::*;
#(
    parameter int W = 19
) (
    input  xf_mode_e             mode,
    input  logic signed [W-1:0]  n [LANES],
    output logic signed [W-1:0]  r [LANES]
);

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        always_comb begin
            if (mode == XF_RSV) begin
                r[l] = '0;
            end else if (l == 0) begin
                r[l] = n[0];
            end else if (l == 1) begin
                r[l] = n[2];
            end else if (l == 2) begin
                r[l] = (mode == XF_INV) ? n[3] : n[1];
            end else begin
                r[l] = (mode == XF_INV) ? n[1] : n[3];
            end
        end
    end

endmodule

// File: rtl/xf4_unit.sv
module xf4_unit
    import xf4_pkg::*;
#(
    parameter  int IN_W  = 16,
    localparam int OUT_W = IN_W + 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    valid_in,
    input  logic [1:0]              mode,
    input  logic signed [IN_W-1:0]  x0,
    input  logic signed [IN_W-1:0]  x1,
    input  logic signed [IN_W-1:0]  x2,
    input  logic signed [IN_W-1:0]  x3,
    output logic                    valid_out,
    output logic signed [OUT_W-1:0] y0,
    output logic signed [OUT_W-1:0] y1,
    output logic signed [OUT_W-1:0] y2,
    output logic signed [OUT_W-1:0] y3
);

    xf_mode_e                mode_e;
    logic signed [OUT_W-1:0] m0, m1, m2, m3;
    logic signed [OUT_W-1:0] n_lane [LANES];
    logic signed [OUT_W-1:0] r_lane [LANES];
    logic signed [OUT_W-1:0] q_lane [LANES];

    assign mode_e = xf_mode_e'(mode);

    xf4_stage1 #(.IN_W(IN_W), .W(OUT_W)) u_stage1 (
        .mode (mode_e),
        .x0   (x0), .x1 (x1), .x2 (x2), .x3 (x3),
        .m0   (m0), .m1 (m1), .m2 (m2), .m3 (m3)
    );

    xf4_stage2 #(.W(OUT_W)) u_stage2 (
        .mode (mode_e),
        .m0   (m0), .m1 (m1), .m2 (m2), .m3 (m3),
        .n    (n_lane)
    );

    xf4_route #(.W(OUT_W)) u_route (
        .mode (mode_e),
        .n    (n_lane),
        .r    (r_lane)
    );

    for (genvar l = 0; l < LANES; l++) begin : g_oreg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                q_lane[l] <= '0;
            end else begin
                q_lane[l] <= r_lane[l];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_out <= 1'b0;
        end else begin
            valid_out <= valid_in;
        end
    end

    assign y0 = q_lane[0];
    assign y1 = q_lane[1];
    assign y2 = q_lane[2];
    assign y3 = q_lane[3];

endmodule

// File: rtl/xf4_unit_chk.sv
module xf4_unit_chk #(
    parameter  int IN_W  = 16,
    localparam int OUT_W = IN_W + 3
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    valid_in,
    input logic [1:0]              mode,
    input logic signed [IN_W-1:0]  x0,
    input logic signed [IN_W-1:0]  x1,
    input logic signed [IN_W-1:0]  x2,
    input logic signed [IN_W-1:0]  x3,
    input logic                    valid_out,
    input logic signed [OUT_W-1:0] y0,
    input logic signed [OUT_W-1:0] y1,
    input logic signed [OUT_W-1:0] y2,
    input logic signed [OUT_W-1:0] y3
);

    logic signed [OUT_W-1:0] s0, s1, s2, s3;
    logic signed [OUT_W-1:0] e_sum, e_f1, e_f2, e_f3;
    logic signed [OUT_W-1:0] e_i0, e_i3, e_h1, e_h3;

    assign s0    = OUT_W'(x0);
    assign s1    = OUT_W'(x1);
    assign s2    = OUT_W'(x2);
    assign s3    = OUT_W'(x3);
    assign e_sum = s0 + s1 + s2 + s3;
    assign e_f1  = (s0 <<< 1) + s1 - s2 - (s3 <<< 1);
    assign e_f2  = s0 - s1 - s2 + s3;
    assign e_f3  = s0 - (s1 <<< 1) + (s2 <<< 1) - s3;
    assign e_i0  = s0 + s1 + s2 + (s3 >>> 1);
    assign e_i3  = s0 - s1 + s2 - (s3 >>> 1);
    assign e_h1  = s0 + s1 - s2 - s3;
    assign e_h3  = s0 - s1 + s2 - s3;

    p_forward_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b00) |=> (y0 == $past(e_sum)) && (y1 == $past(e_f1))
                         && (y2 == $past(e_f2)) && (y3 == $past(e_f3)));

    p_inverse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b01) |=> (y0 == $past(e_i0)) && (y3 == $past(e_i3)));

    p_hadamard_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b10) |=> (y0 == $past(e_sum)) && (y1 == $past(e_h1))
                         && (y2 == $past(e_f2)) && (y3 == $past(e_h3)));

    p_reserved_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b11) |=> (y0 == '0) && (y1 == '0) && (y2 == '0) && (y3 == '0));

    p_valid_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
        valid_in |=> valid_out);

    p_valid_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_in |=> !valid_out);

    p_reset_clear_r6: assert property (@(posedge clk)
        !rst_n |=> !valid_out);

endmodule

bind xf4_unit xf4_unit_chk #(.IN_W(IN_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .valid_in  (valid_in),
    .mode      (mode),
    .x0        (x0),
    .x1        (x1),
    .x2        (x2),
    .x3        (x3),
    .valid_out (valid_out),
    .y0        (y0),
    .y1        (y1),
    .y2        (y2),
    .y3        (y3)
);

// File: tb/xf4_unit_tb.sv
`timescale 1ns/1ps
module xf4_unit_tb;

    localparam int IN_W  = 16;
    localparam int OUT_W = IN_W + 3;
    localparam int NVEC  = 13;

    // doubled coefficients per mode/row/column; an odd value means a half weight
    localparam int CF [3][4][4] = '{
        '{'{2, 2, 2, 2}, '{4, 2, -2, -4}, '{2, -2, -2, 2}, '{2, -4, 4, -2}},
        '{'{2, 2, 2, 1}, '{2, 1, -2, -2}, '{2, -1, -2, 2}, '{2, -2, 2, -1}},
        '{'{2, 2, 2, 2}, '{2, 2, -2, -2}, '{2, -2, -2, 2}, '{2, -2, 2, -2}}
    };

    // {mode, x0, x1, x2, x3}
    localparam logic [65:0] VEC [NVEC] = '{
        {2'b00, 16'h0001, 16'h0002, 16'h0003, 16'h0004},
        {2'b00, 16'hFFFB, 16'h0007, 16'hFFF7, 16'h000B},
        {2'b00, 16'h0064, 16'hFF9C, 16'h0032, 16'hFFCE},
        {2'b01, 16'h0001, 16'h0002, 16'h0003, 16'h0004},
        {2'b01, 16'h000A, 16'hFFFD, 16'h0007, 16'hFFFB},
        {2'b01, 16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hFFFF},
        {2'b10, 16'h0001, 16'h0002, 16'h0003, 16'h0004},
        {2'b10, 16'hFFF8, 16'h0003, 16'h0000, 16'h000C},
        {2'b00, 16'h0000, 16'h0000, 16'h0000, 16'h0000},
        {2'b00, 16'h7FFF, 16'h7FFF, 16'h8000, 16'h8000},
        {2'b01, 16'h8000, 16'h8000, 16'h7FFF, 16'h8000},
        {2'b10, 16'h7FFF, 16'h7FFF, 16'h7FFF, 16'h7FFF},
        {2'b10, 16'h8000, 16'h8000, 16'h8000, 16'h8000}
    };

    logic                    clk = 1'b0;
    logic                    rst_n = 1'b0;
    logic                    valid_in = 1'b0;
    logic [1:0]              mode = 2'b00;
    logic signed [IN_W-1:0]  x0 = '0, x1 = '0, x2 = '0, x3 = '0;
    logic                    valid_out;
    logic signed [OUT_W-1:0] y0, y1, y2, y3;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    xf4_unit #(.IN_W(IN_W)) u_dut (
        .clk (clk), .rst_n (rst_n), .valid_in (valid_in), .mode (mode),
        .x0 (x0), .x1 (x1), .x2 (x2), .x3 (x3),
        .valid_out (valid_out), .y0 (y0), .y1 (y1), .y2 (y2), .y3 (y3)
    );

    function automatic int ref_lane(input logic [1:0] md, input int r,
                                    input int a, input int b, input int c, input int d);
        int xs [4];
        int acc;
        int cf;
        xs[0] = a; xs[1] = b; xs[2] = c; xs[3] = d;
        acc = 0;
        if (md == 2'b11) return 0;
        for (int j = 0; j < 4; j++) begin
            cf = CF[md][r][j];
            if (cf == 1)       acc += (xs[j] >>> 1);
            else if (cf == -1) acc -= (xs[j] >>> 1);
            else               acc += (cf / 2) * xs[j];
        end
        return acc;
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic drive(input logic [1:0] md, input logic [15:0] a, input logic [15:0] b,
                         input logic [15:0] c, input logic [15:0] d, input logic v);
        @(negedge clk);
        mode = md; x0 = a; x1 = b; x2 = c; x3 = d; valid_in = v;
        @(posedge clk);
        #1;
    endtask

    task automatic check_lanes(input string tag, input logic [1:0] md,
                               input logic [15:0] a, input logic [15:0] b,
                               input logic [15:0] c, input logic [15:0] d);
        int ia, ib, ic, id;
        ia = int'($signed(a)); ib = int'($signed(b));
        ic = int'($signed(c)); id = int'($signed(d));
        check({tag, " y0"}, int'(y0), ref_lane(md, 0, ia, ib, ic, id));
        check({tag, " y1"}, int'(y1), ref_lane(md, 1, ia, ib, ic, id));
        check({tag, " y2"}, int'(y2), ref_lane(md, 2, ia, ib, ic, id));
        check({tag, " y3"}, int'(y3), ref_lane(md, 3, ia, ib, ic, id));
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        string tag;
        repeat (3) @(posedge clk);
        #1;
        // R6: reset state
        check("R6 valid_out in reset", int'(valid_out), 0);
        check("R6 y0 in reset", int'(y0), 0);
        check("R6 y3 in reset", int'(y3), 0);
        @(negedge clk);
        rst_n = 1'b1;

        // table walk: R1 forward, R2 inverse, R3 Hadamard, R7 extremes
        for (int i = 0; i < NVEC; i++) begin
            logic [1:0] md;
            md = VEC[i][65:64];
            if (i >= 9)          tag = "R7";
            else if (md == 2'b00) tag = "R1";
            else if (md == 2'b01) tag = "R2";
            else                  tag = "R3";
            drive(md, VEC[i][63:48], VEC[i][47:32], VEC[i][31:16], VEC[i][15:0], 1'b1);
            check_lanes(tag, md, VEC[i][63:48], VEC[i][47:32], VEC[i][31:16], VEC[i][15:0]);
            check("R5 valid_out high", int'(valid_out), 1);
        end

        // R2: floor rounding of odd negative half terms (y = -5, 1, -1, 5)
        drive(2'b01, 16'h0000, 16'hFFFD, 16'h0000, 16'hFFFD, 1'b1);
        check("R2 floor y0", int'(y0), -5);
        check("R2 floor y1", int'(y1), 1);
        check("R2 floor y2", int'(y2), -1);
        check("R2 floor y3", int'(y3), 5);

        // R4: reserved code after a nonzero result
        drive(2'b00, 16'h0011, 16'h0022, 16'h0033, 16'h0044, 1'b1);
        drive(2'b11, 16'h1234, 16'hF00D, 16'h7FFF, 16'h8000, 1'b1);
        check_lanes("R4 reserved", 2'b11, 16'h1234, 16'hF00D, 16'h7FFF, 16'h8000);

        // R5: data registered without strobe, strobe follows with one cycle delay
        drive(2'b10, 16'h0005, 16'h0006, 16'h0007, 16'h0008, 1'b0);
        check("R5 valid_out low", int'(valid_out), 0);
        check_lanes("R5 data without strobe", 2'b10, 16'h0005, 16'h0006, 16'h0007, 16'h0008);
        drive(2'b00, 16'h0002, 16'h0003, 16'h0004, 16'h0005, 1'b1);
        check("R5 valid_out returns", int'(valid_out), 1);
        check_lanes("R5 R1 mode switch", 2'b00, 16'h0002, 16'h0003, 16'h0004, 16'h0005);

        // R6: reset in mid-run clears outputs
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        check("R6 mid-run valid_out", int'(valid_out), 0);
        check("R6 mid-run y1", int'(y1), 0);
        check("R6 mid-run y2", int'(y2), 0);
        @(negedge clk);
        rst_n = 1'b1;

        done = 1'b1;
        $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule